// File: doc/BRIEF.md
# Daisy-Chain DAC Frame Master

This block is the host side of a serial link to a chain of identical octal DAC devices that share one serial clock and one active-low chip-select line. Only the nearest device receives data from the master; each device forwards its shift-register output to the next device. Every device therefore needs a 32-bit slot in one long frame: eight zero padding bits followed by its 24-bit command, address and data word.

Software offers words one at a time on a valid/ready port. Each word is tagged with a device index, and the final word of a batch carries a `last` flag. Devices that receive no word in a batch get the no-operation word. On `last` the block opens the chip-select window and shifts out the assembled frame. The farthest device's slot goes first. The serial clock is derived from the system clock by an even divider. Once chip-select rises, all devices act at once. The bits that return from the far end of the chain are sampled on every rising clock edge and published as the previous frame.

Top module: `dac_chain_master`

## Requirements
- R1: After reset, `cs_n` is 1, `sck`, `sdi` and `busy` are 0, `in_ready` is 1 and `rx_frame` is all zero.
- R2: Each frame is exactly one `cs_n`-low window that holds exactly NDEV*32 rising edges of `sck`, and `sck` is never high while `cs_n` is high.
- R3: A device at chain index k (index 0 is the device wired to `sdi`) receives a 32-bit slot. The slot's top 8 bits are zero and its low 24 bits are the word given for index k. Slots are sent from the highest index down to index 0, each most significant bit first.
- R4: An index that received no word since the previous frame is sent the no-operation word 24'hF00000, which has command bits [23:20] equal to 4'b1111 and all other bits zero. Stored words are discarded once a frame starts.
- R5: `sck` idles low. Each high phase and each low phase inside a frame lasts DIV/2 system clocks. `sdi` never changes while `sck` is high.
- R6: `cs_n` falls at least DIV/2 system clocks before the first rising edge of `sck`. It rises at least DIV/2 system clocks after the last falling edge.
- R7: After `cs_n` rises, `busy` stays high for at least CSH_CYC further clocks, so the chip-select high pulse between frames is at least CSH_CYC clocks.
- R8: `busy` rises when the first word of a batch is accepted. `in_ready` is low from acceptance of the `last` word until `busy` falls, and a word offered in that time is not stored.
- R9: When `cs_n` rises, `rx_frame` takes the NDEV*32 values of `dac_sdo` sampled at each rising edge of `sck`, with the first sample in the most significant bit.
- R10: If two words for the same index are accepted before a frame starts, the later one is sent. A word whose index is NDEV or higher is dropped, but its `last` flag still starts the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word offer |
| in_ready | output | 1 | Word can be taken this cycle |
| in_dev | input | IDX_W | Chain index of the target device |
| in_last | input | 1 | Final word of the batch; starts the frame |
| in_word | input | 24 | Command, address and data word |
| busy | output | 1 | Batch being collected or frame in flight |
| sck | output | 1 | Serial clock to all devices |
| cs_n | output | 1 | Shared active-low chip-select/load |
| sdi | output | 1 | Serial data to the first device |
| dac_sdo | input | 1 | Serial data returned from the last device |
| rx_frame | output | NDEV*32 | Bits returned during the previous frame |

## Verification
A wrong slot order or a stale stored word shows up as a misplaced or repeated command in the device registers at the very next chip-select rise. It then appears again one frame later in `rx_frame`, because that port echoes the chain's earlier contents. An off-by-one in the bit counter changes the number of serial clock edges. That leaves every device misaligned by a bit, so all executed words look shifted within the same frame. A timing-phase error shows at the pins within one serial clock period as a wrong high or low length, or as `sdi` moving while `sck` is high.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  localparam int CMD_W  = 24;
  localparam int PAD_W  = 8;
  localparam int SLOT_W = CMD_W + PAD_W;
  localparam logic [CMD_W-1:0] NOOP_WORD = 24'hF00000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } dcm_state_e;
endpackage

// File: rtl/dcm_slot_store.sv
module dcm_slot_store import dcm_pkg::*; #(
  parameter int NDEV  = 3,
  parameter int IDX_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [CMD_W-1:0]         wr_word,
  input  logic                     clear,
  output logic [NDEV*SLOT_W-1:0]   frame_o
);
  logic [NDEV-1:0] vld;

  for (genvar k = 0; k < NDEV; k++) begin : g_slot
    logic [CMD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        vld[k] <= 1'b0;
        word_q <= '0;
      end else if (clear) begin
        vld[k] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(k))) begin
        vld[k] <= 1'b1;
        word_q <= wr_word;
      end
    end
    // highest index sits at the top of the frame and leaves first
    assign frame_o[k*SLOT_W +: SLOT_W] = {{PAD_W{1'b0}}, (vld[k] ? word_q : NOOP_WORD)};
  end

  // R4: a cleared store holds no pending word on the next cycle
  a_r4_cleared_after_load: assert property (@(posedge clk) disable iff (rst)
    clear |=> (vld == '0));
endmodule

// File: rtl/dcm_sck_timer.sv
module dcm_sck_timer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF  = DIV / 2;
  localparam int PH_W  = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PH_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst || !run)            ph <= '0;
    else if (ph == PH_W'(DIV-1)) ph <= '0;
    else                        ph <= ph + 1'b1;
  end

  assign rise_o = run && (ph == PH_W'(HALF-1));
  assign fall_o = run && (ph == PH_W'(DIV-1));

  // R5: a rising strobe is always followed by a falling one, never by another rise first
  a_r5_no_double_rise: assert property (@(posedge clk) disable iff (rst)
    (rise_o && HALF > 1) |=> !rise_o);
endmodule

// File: rtl/dac_chain_master.sv
module dac_chain_master import dcm_pkg::*; #(
  parameter int NDEV    = 3,
  parameter int DIV     = 4,
  parameter int CSH_CYC = 2,
  parameter int IDX_W   = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [IDX_W-1:0]       in_dev,
  input  logic                   in_last,
  input  logic [CMD_W-1:0]       in_word,
  output logic                   busy,
  output logic                   sck,
  output logic                   cs_n,
  output logic                   sdi,
  input  logic                   dac_sdo,
  output logic [NDEV*SLOT_W-1:0] rx_frame
);
  localparam int NB       = NDEV * SLOT_W;
  localparam int HALF     = DIV / 2;
  localparam int CNT_W    = $clog2(NB);
  localparam int WAIT_MAX = (HALF > CSH_CYC) ? HALF : CSH_CYC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  dcm_state_e        state;
  logic              collecting;
  logic [NB-1:0]     frame_w;
  logic [NB-1:0]     tx_sh;
  logic [NB-1:0]     rx_sh;
  logic [CNT_W-1:0]  bitcnt;
  logic [WAIT_W-1:0] wcnt;
  logic              accept;
  logic              rise_s;
  logic              fall_s;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign busy     = collecting || (state != ST_IDLE);

  dcm_slot_store #(.NDEV(NDEV), .IDX_W(IDX_W)) u_slots (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (accept),
    .wr_idx (in_dev),
    .wr_word(in_word),
    .clear  (state == ST_LOAD),
    .frame_o(frame_w)
  );

  dcm_sck_timer #(.DIV(DIV)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .run   (state == ST_SHIFT),
    .rise_o(rise_s),
    .fall_o(fall_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      collecting <= 1'b0;
      sck        <= 1'b0;
      cs_n       <= 1'b1;
      sdi        <= 1'b0;
      tx_sh      <= '0;
      rx_sh      <= '0;
      rx_frame   <= '0;
      bitcnt     <= '0;
      wcnt       <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            collecting <= 1'b1;
            if (in_last) state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          tx_sh  <= frame_w;
          sdi    <= frame_w[NB-1];
          rx_sh  <= '0;
          cs_n   <= 1'b0;
          bitcnt <= '0;
          state  <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (rise_s) begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[NB-2:0], dac_sdo};
          end
          if (fall_s) begin
            sck <= 1'b0;
            if (bitcnt == CNT_W'(NB-1)) begin
              sdi   <= 1'b0;
              wcnt  <= WAIT_W'(HALF-1);
              state <= ST_TAIL;
            end else begin
              tx_sh  <= {tx_sh[NB-2:0], 1'b0};
              sdi    <= tx_sh[NB-2];
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (wcnt == '0) begin
            cs_n     <= 1'b1;
            rx_frame <= rx_sh;
            wcnt     <= WAIT_W'(CSH_CYC-1);
            state    <= ST_GAP;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (wcnt == '0) begin
            collecting <= 1'b0;
            state      <= ST_IDLE;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: data is held for the whole high phase of the serial clock
  a_r5_sdi_stable_high: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(sdi));

  // R2: serial clock pulses only inside the chip-select window
  a_r2_sck_inside_window: assert property (@(posedge clk) disable iff (rst)
    sck |-> !cs_n);

  // R6: chip-select rises with the serial clock already low
  a_r6_cs_rise_sck_low: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (!sck && !$past(sck)));

  // R7: the block still reports busy when chip-select rises
  a_r7_busy_at_cs_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> busy);

  // R8: nothing is accepted while a frame is in flight
  a_r8_no_accept_inflight: assert property (@(posedge clk) disable iff (rst)
    (!cs_n) |-> !in_ready);
endmodule

// File: tb/dac_chain_master_tb.sv
module dac_chain_master_tb;
  localparam int NDEV    = 3;
  localparam int DIV     = 4;
  localparam int CSH_CYC = 2;
  localparam int HALF    = DIV / 2;
  localparam int IDX_W   = 2;
  localparam int NB      = NDEV * 32;
  localparam logic [23:0] NOOP = 24'hF00000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [IDX_W-1:0] in_dev = '0;
  logic in_last = 1'b0;
  logic [23:0] in_word = '0;
  logic busy, sck, cs_n, sdi, dac_sdo;
  logic [NB-1:0] rx_frame;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  dac_chain_master #(.NDEV(NDEV), .DIV(DIV), .CSH_CYC(CSH_CYC), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_dev(in_dev), .in_last(in_last), .in_word(in_word), .busy(busy),
    .sck(sck), .cs_n(cs_n), .sdi(sdi), .dac_sdo(dac_sdo), .rx_frame(rx_frame)
  );

  // chain of device models: shift on rising sck, present on falling sck
  logic [31:0] dev_sh [NDEV];
  logic        dev_so [NDEV];
  logic [31:0] exec_q [NDEV];
  int rises = 0;
  int last_rises = 0;
  int frames = 0;

  initial begin
    for (int k = 0; k < NDEV; k++) begin
      dev_sh[k] = '0;
      dev_so[k] = 1'b0;
      exec_q[k] = '0;
    end
  end

  assign dac_sdo = dev_so[NDEV-1];

  always @(posedge sck) begin
    if (!cs_n) begin
      rises <= rises + 1;
      for (int k = 0; k < NDEV; k++)
        dev_sh[k] <= {dev_sh[k][30:0], (k == 0) ? sdi : dev_so[k-1]};
    end
  end

  always @(negedge sck)
    for (int k = 0; k < NDEV; k++) dev_so[k] <= dev_sh[k][31];

  always @(negedge cs_n) rises <= 0;

  always @(posedge cs_n) begin
    if (!rst) begin
      last_rises <= rises;
      frames     <= frames + 1;
      for (int k = 0; k < NDEV; k++) exec_q[k] <= dev_sh[k];
    end
  end

  // pin timing monitor
  logic p_sck = 1'b0, p_sdi = 1'b0, p_cs = 1'b1, p_busy = 1'b0;
  int run = 0, lead = 0, csh = 100;
  bit seen_rise = 0;
  int v_sdi = 0, v_hi = 0, v_lo = 0, v_lead = 0, v_tail = 0, v_gap = 0, v_busy = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sck && p_sck && (sdi != p_sdi)) v_sdi++;
      if (!p_cs && cs_n && run < HALF) v_tail++;
      if (sck == p_sck) run++;
      else begin
        if (p_sck && run != HALF) v_hi++;
        if (!p_sck && seen_rise && run != HALF) v_lo++;
        if (sck && !seen_rise) begin
          if (lead < HALF) v_lead++;
          seen_rise = 1;
        end
        run = 1;
      end
      if (!cs_n && !seen_rise && !sck) lead++;
      if (cs_n) begin seen_rise = 0; lead = 0; end
      if (cs_n) csh++;
      else begin
        if (p_cs && csh < CSH_CYC) v_gap++;
        csh = 0;
      end
      if (p_busy && !busy && csh < CSH_CYC) v_busy++;
    end
    p_sck = sck; p_sdi = sdi; p_cs = cs_n; p_busy = busy;
  end

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input int idx, input logic [23:0] w, input bit last);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_dev = IDX_W'(idx); in_word = w; in_last = last;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_frame();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "cs_n", 128'(cs_n), 128'(1));
    chk("R1", "sck", 128'(sck), 128'(0));
    chk("R1", "sdi", 128'(sdi), 128'(0));
    chk("R1", "busy", 128'(busy), 128'(0));
    chk("R1", "in_ready", 128'(in_ready), 128'(1));
    chk("R1", "rx_frame", 128'(rx_frame), 128'(0));
  endtask

  task automatic t_full();
    send(0, 24'h301234, 1'b0);
    chk("R8", "busy while collecting", 128'(busy), 128'(1));
    chk("R8", "ready while collecting", 128'(in_ready), 128'(1));
    send(1, 24'h0256A5, 1'b0);
    send(2, 24'h3789FE, 1'b1);
    wait_frame();
    chk("R2", "rising edges per frame", 128'(last_rises), 128'(NB));
    chk("R3", "dev0 slot", 128'(exec_q[0]), 128'({8'h00, 24'h301234}));
    chk("R3", "dev1 slot", 128'(exec_q[1]), 128'({8'h00, 24'h0256A5}));
    chk("R3", "dev2 slot", 128'(exec_q[2]), 128'({8'h00, 24'h3789FE}));
    chk("R9", "rx after first frame", 128'(rx_frame), 128'(0));
  endtask

  task automatic t_partial();
    send(1, 24'h410000, 1'b1);
    wait_frame();
    chk("R4", "dev0 no-op", 128'(exec_q[0]), 128'({8'h00, NOOP}));
    chk("R4", "dev1 word", 128'(exec_q[1]), 128'({8'h00, 24'h410000}));
    chk("R4", "dev2 no-op", 128'(exec_q[2]), 128'({8'h00, NOOP}));
    chk("R9", "rx echoes previous chain", 128'(rx_frame),
        128'({8'h00, 24'h3789FE, 8'h00, 24'h0256A5, 8'h00, 24'h301234}));
  endtask

  task automatic t_overwrite();
    send(2, 24'h111111, 1'b0);
    send(2, 24'h3F0F0F, 1'b0);
    send(3, 24'hABCDEF, 1'b1);
    wait_frame();
    chk("R10", "dev2 keeps later word", 128'(exec_q[2]), 128'({8'h00, 24'h3F0F0F}));
    chk("R10", "out-of-range index dropped, dev0", 128'(exec_q[0]), 128'({8'h00, NOOP}));
    chk("R4", "dev1 not repeated", 128'(exec_q[1]), 128'({8'h00, NOOP}));
    chk("R2", "rising edges per frame", 128'(last_rises), 128'(NB));
    chk("R9", "rx echoes partial frame", 128'(rx_frame),
        128'({8'h00, NOOP, 8'h00, 24'h410000, 8'h00, NOOP}));
  endtask

  task automatic t_refuse();
    int ready_seen = 0;
    send(0, 24'h200001, 1'b1);
    in_valid = 1'b1; in_dev = 2'd1; in_word = 24'h0EEEEE; in_last = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (in_ready) ready_seen++;
    end
    in_valid = 1'b0; in_last = 1'b0;
    chk("R8", "ready low in flight", 128'(ready_seen), 128'(0));
    wait_frame();
    chk("R3", "dev0 word", 128'(exec_q[0]), 128'({8'h00, 24'h200001}));
    send(2, 24'h355555, 1'b1);
    wait_frame();
    chk("R8", "refused word not stored", 128'(exec_q[1]), 128'({8'h00, NOOP}));
    chk("R3", "dev2 word", 128'(exec_q[2]), 128'({8'h00, 24'h355555}));
  endtask

  task automatic t_timing();
    chk("R5", "sdi moved while sck high", 128'(v_sdi), 128'(0));
    chk("R5", "high phase length", 128'(v_hi), 128'(0));
    chk("R5", "low phase length", 128'(v_lo), 128'(0));
    chk("R6", "cs to first rise", 128'(v_lead), 128'(0));
    chk("R6", "last fall to cs rise", 128'(v_tail), 128'(0));
    chk("R7", "cs high gap", 128'(v_gap), 128'(0));
    chk("R7", "busy through cs high time", 128'(v_busy), 128'(0));
    chk("R2", "frames seen", 128'(frames), 128'(5));
    chk("R5", "sck idle", 128'(sck), 128'(0));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_full();
        t_partial();
        t_overwrite();
        t_refuse();
        t_timing();
      end
      begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule